// File: doc/BRIEF.md
# Power-Fail Output Sequencer

This block drives the active-low power-fail output of a timekeeping device. Its inputs are digitized supply-monitor flags: a comparator result that says the power-fail input has fallen below its threshold, a flag that says main VCC sits above the upper deselect threshold, and a battery-backup indication. It does not simply pass the comparator through. While the device runs from its battery, the output is held low. When power comes back, the output is forced high for a programmable write-protect interval, whatever the comparator reports. Only after that interval does the output follow the comparator again.

The three monitor flags arrive from the analog domain. Each passes through a configurable synchronizer (`SYNC_STAGES` flops, or none). A three-state controller then acts on them: backup, recovering and active. A recovery timer measures the write-protect window in clock cycles. The output is a flop, so it changes only on a clock edge. If power is lost again in the middle of the window, the window is cut short and the output drops at once. The next return of power starts a full window.

An output level of 1 means "power good". A level of 0 means "power failing or on battery". An input change reaches the output after `SYNC_STAGES + 1` clock edges.

Top module: `pfo_sequencer`

## Requirements
- R1: While reset is asserted, and after it is released until power is seen as present, the block is in backup and `pfo_n_o` is 0.
- R2: When `vcc_ok_i` is 0, `pfo_n_o` goes to 0 after `SYNC_STAGES + 1` edges. It stays 0 however `pfi_low_i` moves.
- R3: When `vcc_ok_i` is 1 and `batt_backup_i` is 0 while in backup, `pfo_n_o` becomes 1 at edge E0, which is `SYNC_STAGES + 1` edges after the change. It stays 1 for exactly `REC_CYCLES` cycles, regardless of `pfi_low_i`.
- R4: From edge E0 + `REC_CYCLES` onward, while power stays present, `pfo_n_o` equals the inverse of `pfi_low_i`. A value of 1 on `pfi_low_i` gives 0 on the output, and 0 gives 1.
- R5: Losing power during the recovery window returns the block to backup and drives `pfo_n_o` to 0 after `SYNC_STAGES + 1` edges. The next return of power grants a complete `REC_CYCLES` window.
- R6: Every input change reaches `pfo_n_o` after exactly `SYNC_STAGES + 1` rising edges, and no earlier.
- R7: `batt_backup_i` = 1 alone counts as loss of power, even while `vcc_ok_i` is 1. It forces the output to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pfi_low_i | input | 1 | 1 when the power-fail input is below its threshold |
| vcc_ok_i | input | 1 | 1 when main VCC is above the upper deselect threshold |
| batt_backup_i | input | 1 | 1 while the device runs from the backup battery |
| pfo_n_o | output | 1 | Registered power-fail output, active low |

## Verification
The hardest situation to reach from the ports is an abort part-way through the write-protect window, followed by a clean return of power. Only this sequence shows that the recovery timer restarts from zero rather than resuming. The stimulus first brings power up with the comparator reporting a failure, so the forced-high window can be told apart from tracking. It drops `vcc_ok_i` a few cycles into the window and restores it. The bench then confirms that the output stays high for the full `REC_CYCLES` again before it falls to the comparator value.

// File: rtl/pfo_pkg.sv
`timescale 1ns/1ps
package pfo_pkg;

   typedef enum logic [1:0] {
      ST_BACKUP  = 2'd0,
      ST_RECOVER = 2'd1,
      ST_ACTIVE  = 2'd2
   } pfo_state_e;

   // Bit positions of the monitor flags inside the synchronizer vector
   localparam int unsigned MON_PFI  = 0;
   localparam int unsigned MON_VCC  = 1;
   localparam int unsigned MON_BATT = 2;
   localparam int unsigned MON_W    = 3;

   // Safe (power-lost) value loaded into every synchronizer stage on reset
   localparam logic [MON_W-1:0] MON_SAFE = 3'b101;

endpackage

// File: rtl/pfo_sync.sv
`timescale 1ns/1ps
module pfo_sync #(
   parameter int unsigned WIDTH   = 3,
   parameter int unsigned STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   if (STAGES > 8) begin : g_bad_stages
      $error("pfo_sync: STAGES must be 8 or fewer");
   end

   if (STAGES == 0) begin : g_bypass
      assign q_o = d_i;
   end else begin : g_chain
      logic [WIDTH-1:0] chain_q [STAGES];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < int'(STAGES); i++) chain_q[i] <= RST_VAL;
         end else begin
            chain_q[0] <= d_i;
            for (int i = 1; i < int'(STAGES); i++) chain_q[i] <= chain_q[i-1];
         end
      end

      assign q_o = chain_q[STAGES-1];
   end

endmodule

// File: rtl/pfo_rec_timer.sv
`timescale 1ns/1ps
module pfo_rec_timer #(
   parameter int unsigned CNT_W      = 16,
   parameter int unsigned REC_CYCLES = 100
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   output logic done_o
);

   localparam logic [CNT_W-1:0] LAST = CNT_W'(REC_CYCLES - 1);

   if (REC_CYCLES < 1 || REC_CYCLES > (2 ** CNT_W)) begin : g_bad_len
      $error("pfo_rec_timer: REC_CYCLES must fit in CNT_W bits");
   end

   logic [CNT_W-1:0] cnt_q;
   logic             at_last;

   assign at_last = (cnt_q == LAST);
   assign done_o  = run_i && at_last;

   // Counts only while running; any cycle outside the window clears it
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   cnt_q <= '0;
      else if (run_i && !at_last)   cnt_q <= cnt_q + 1'b1;
      else                          cnt_q <= '0;
   end

   // R3: the count never passes the final window cycle
   a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LAST);

   // R5: a cycle outside the window leaves the timer at zero (restart)
   a_r5_clear_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !run_i |=> cnt_q == '0);

endmodule

// File: rtl/pfo_fsm.sv
`timescale 1ns/1ps
module pfo_fsm
   import pfo_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic pfi_low_i,
   input  logic power_lost_i,
   input  logic rec_done_i,
   output logic rec_run_o,
   output logic pfo_n_o
);

   pfo_state_e state_q, state_d;
   logic       pfo_q, pfo_d;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_BACKUP:  if (!power_lost_i) state_d = ST_RECOVER;
         ST_RECOVER: begin
            if (power_lost_i)    state_d = ST_BACKUP;
            else if (rec_done_i) state_d = ST_ACTIVE;
         end
         ST_ACTIVE:  if (power_lost_i) state_d = ST_BACKUP;
         default:    state_d = ST_BACKUP;
      endcase
   end

   always_comb begin
      unique case (state_d)
         ST_RECOVER: pfo_d = 1'b1;
         ST_ACTIVE:  pfo_d = !pfi_low_i;
         default:    pfo_d = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_BACKUP;
         pfo_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         pfo_q   <= pfo_d;
      end
   end

   assign rec_run_o = (state_q == ST_RECOVER);
   assign pfo_n_o   = pfo_q;

   // R2: lost power seen in a cycle means a low output in the next
   a_r2_lost_low: assert property (@(posedge clk) disable iff (!rst_n)
      power_lost_i |=> !pfo_n_o);

   // R3: the output is high throughout the recovery window
   a_r3_window_high: assert property (@(posedge clk) disable iff (!rst_n)
      rec_run_o |-> pfo_n_o);

   // R4: in the active state the output tracks the comparator
   a_r4_track: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_ACTIVE && !power_lost_i) |=> pfo_n_o == !$past(pfi_low_i));

   // R5: a loss inside the window aborts straight to backup
   a_r5_abort: assert property (@(posedge clk) disable iff (!rst_n)
      (rec_run_o && power_lost_i) |=> state_q == ST_BACKUP);

   // R3: leaving backup always passes through the recovery window
   a_r3_no_skip: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_BACKUP) |=> state_q != ST_ACTIVE);

endmodule

// File: rtl/pfo_sequencer.sv
`timescale 1ns/1ps
module pfo_sequencer
   import pfo_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned CNT_W       = 16,
   parameter int unsigned REC_CYCLES  = 100
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pfi_low_i,
   input  logic vcc_ok_i,
   input  logic batt_backup_i,
   output logic pfo_n_o
);

   logic [MON_W-1:0] mon_raw, mon_s;
   logic             power_lost, rec_run, rec_done;

   always_comb begin
      mon_raw           = '0;
      mon_raw[MON_PFI]  = pfi_low_i;
      mon_raw[MON_VCC]  = vcc_ok_i;
      mon_raw[MON_BATT] = batt_backup_i;
   end

   pfo_sync #(
      .WIDTH   (MON_W),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (MON_SAFE)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (mon_raw),
      .q_o   (mon_s)
   );

   // R7: battery indication alone counts as lost power
   assign power_lost = mon_s[MON_BATT] || !mon_s[MON_VCC];

   pfo_rec_timer #(
      .CNT_W      (CNT_W),
      .REC_CYCLES (REC_CYCLES)
   ) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .run_i  (rec_run),
      .done_o (rec_done)
   );

   pfo_fsm u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .pfi_low_i    (mon_s[MON_PFI]),
      .power_lost_i (power_lost),
      .rec_done_i   (rec_done),
      .rec_run_o    (rec_run),
      .pfo_n_o      (pfo_n_o)
   );

   // R1: the output is low immediately after reset release
   a_r1_reset_low: assert property (@(posedge clk)
      $rose(rst_n) |-> !pfo_n_o);

endmodule

// File: tb/tb_pfo_sequencer.sv
`timescale 1ns/1ps
module tb_pfo_sequencer;

   localparam int SYNC = 2;
   localparam int REC  = 20;
   localparam int LAT  = SYNC + 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pfi_low = 1'b1;
   logic vcc_ok = 1'b0;
   logic batt = 1'b1;
   logic pfo_n;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   pfo_sequencer #(
      .SYNC_STAGES (SYNC),
      .CNT_W       (16),
      .REC_CYCLES  (REC)
   ) dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .pfi_low_i     (pfi_low),
      .vcc_ok_i      (vcc_ok),
      .batt_backup_i (batt),
      .pfo_n_o       (pfo_n)
   );

   task automatic chk(input string req, input logic act, input logic exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: pfo_n_o=%b expected %b at %0t", req, act, exp, $time);
      end
   endtask

   // wait n rising edges, then settle on the following falling edge
   task automatic step(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic t_reset;
      step(2);
      chk("R1 during reset", pfo_n, 1'b0);
      rst_n = 1'b1;
      step(5);
      chk("R1 after release", pfo_n, 1'b0);
   endtask

   task automatic t_power_up;
      vcc_ok = 1'b1; batt = 1'b0; pfi_low = 1'b1;
      step(LAT - 1);
      chk("R6 not early", pfo_n, 1'b0);
      step(1);
      chk("R3 window start", pfo_n, 1'b1);
      pfi_low = 1'b0;
      step(4);
      chk("R3 comparator ignored", pfo_n, 1'b1);
      pfi_low = 1'b1;
      step(REC - 1 - 4);
      chk("R3 last window cycle", pfo_n, 1'b1);
      step(1);
      chk("R4 follows comparator low", pfo_n, 1'b0);
   endtask

   task automatic t_track;
      pfi_low = 1'b0;
      step(LAT - 1);
      chk("R6 latency hold", pfo_n, 1'b0);
      step(1);
      chk("R4 follows comparator high", pfo_n, 1'b1);
      pfi_low = 1'b1;
      step(LAT);
      chk("R4 follows comparator low again", pfo_n, 1'b0);
      pfi_low = 1'b0;
      step(LAT);
      chk("R4 follows comparator high again", pfo_n, 1'b1);
   endtask

   task automatic t_batt_only;
      batt = 1'b1;
      step(LAT);
      chk("R7 battery forces low", pfo_n, 1'b0);
      pfi_low = 1'b1;
      step(3);
      pfi_low = 1'b0;
      step(LAT + 2);
      chk("R2 comparator ignored in backup", pfo_n, 1'b0);
      batt = 1'b0;
      step(LAT + REC);
      chk("R4 active after battery return", pfo_n, 1'b1);
   endtask

   task automatic t_vcc_drop;
      vcc_ok = 1'b0;
      step(LAT);
      chk("R2 vcc drop forces low", pfo_n, 1'b0);
      step(10);
      chk("R2 stays low", pfo_n, 1'b0);
   endtask

   task automatic t_abort;
      pfi_low = 1'b1;
      vcc_ok  = 1'b1;
      step(LAT);
      chk("R5 first window start", pfo_n, 1'b1);
      step(5);
      vcc_ok = 1'b0;
      step(LAT);
      chk("R5 abort to low", pfo_n, 1'b0);
      vcc_ok = 1'b1;
      step(LAT);
      chk("R5 second window start", pfo_n, 1'b1);
      step(REC - 1);
      chk("R5 full window granted", pfo_n, 1'b1);
      step(1);
      chk("R5 window end tracks", pfo_n, 1'b0);
   endtask

   initial begin
      @(negedge clk);
      t_reset();
      t_power_up();
      t_track();
      t_batt_only();
      t_vcc_drop();
      t_abort();
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: run did not finish, actual hung expected done");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

endmodule